// File: doc/BRIEF.md
# Dual-Prediction Fetch Group Former

This block sits at the front of an instruction fetch pipeline. Each cycle it takes the cache line that holds the current fetch address, together with the branch-type flags that were recorded beside each instruction slot when the line was filled. From these it forms one fetch group: a run of consecutive 4-byte instruction slots that begins at the fetch address. It also works out the address that the next cycle will fetch from. The group is offered to a decode queue, so that fetch runs independently of the decoders.

Two taken/not-taken predictions are used in each cycle. The first conditional branch met in the group uses the first prediction. If that prediction is not-taken, the group continues past the branch. The next branch always ends the group. Only one redirect target is chosen per cycle. A return takes the return-stack top. A taken conditional branch, a jump or a call takes the branch-target-buffer output. Any other group continues at the sequential address after its last slot.

A group ends at the first of these points: eight slots gathered, the last slot of the line, or a branch that terminates the run. When the queue is full, or when no line is present, the block offers nothing and keeps its fetch address unchanged.

Top module: `fetch_group_former`

## Requirements
- R1: While reset is asserted, `fetch_addr` equals the parameter `RESET_ADDR` (default 0x1000). After reset is released, with `line_valid` low, `grp_push` is 0.
- R2: When the slots ahead carry no branch flags and room remains in the line, the group holds exactly 8 slots.
- R3: The group never extends past slot 15 of the line. The start slot is `fetch_addr[5:2]`, so a group starting at slot s holds at most 16-s slots.
- R4: `grp_mask` has bits 0 to `grp_len`-1 set and every other bit clear.
- R5: When the first conditional branch in the group (flag in `slot_cond`) is predicted not-taken by `pred_first`=0, gathering continues past it.
- R6: When the first conditional branch is predicted taken by `pred_first`=1, the group ends at that slot and `grp_next` equals `btb_target`.
- R7: A second conditional branch in the group always ends the group. If `pred_second`=1, `grp_next` equals `btb_target`. If `pred_second`=0, `grp_next` is the sequential address.
- R8: A slot flagged in `slot_ret` ends the group, and `grp_next` equals `ras_top`, even when `btb_target` differs.
- R9: A slot flagged in `slot_jump` ends the group at any position in the group, and `grp_next` equals `btb_target`.
- R10: When the group does not end at a redirecting branch, `grp_next` equals `fetch_addr` + 4·`grp_len`.
- R11: When `q_full` is 1 or `line_valid` is 0, `grp_push` is 0, and `fetch_addr` keeps its value at the next clock edge.
- R12: When `grp_push` is 1, `fetch_addr` takes the value of `grp_next` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | The cache line for `fetch_addr` is present |
| slot_cond | input | 16 | Per-slot flag: conditional branch |
| slot_jump | input | 16 | Per-slot flag: unconditional jump or call |
| slot_ret | input | 16 | Per-slot flag: return |
| pred_first | input | 1 | Taken prediction for the first conditional branch in the group |
| pred_second | input | 1 | Taken prediction for the second conditional branch in the group |
| btb_target | input | 32 | Branch-target-buffer target for the branch that ends the group |
| ras_top | input | 32 | Top entry of the return-address stack |
| q_full | input | 1 | Decode queue cannot accept a group |
| fetch_addr | output | 32 | Current fetch address, which is also the group start |
| grp_push | output | 1 | Group is written into the decode queue this cycle |
| grp_mask | output | 8 | Valid bit per group slot |
| grp_len | output | 4 | Number of slots in the group, 0 to 8 |
| grp_next | output | 32 | Next fetch address |

## Verification
The group outputs `grp_mask`, `grp_len`, `grp_next` and `grp_push` are combinational from `fetch_addr` and the line inputs. They are due in the same cycle as the stimulus. The bench therefore drives the inputs on the falling edge and samples these outputs a few nanoseconds later, before the next rising edge. `fetch_addr` is the only register. Its new value is due one rising edge after the stimulus, so the bench reads it 1 ns after that edge. Each scenario first steers `fetch_addr` to a known start by pushing a one-slot group that ends in a return.

// File: rtl/fetch_group_former.sv
module fetch_group_former #(
  parameter int GROUP_MAX  = 8,
  parameter int LINE_SLOTS = 16,
  parameter int ADDR_W     = 32,
  parameter logic [31:0] RESET_ADDR = 32'h0000_1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         line_valid,
  input  logic [LINE_SLOTS-1:0]        slot_cond,
  input  logic [LINE_SLOTS-1:0]        slot_jump,
  input  logic [LINE_SLOTS-1:0]        slot_ret,
  input  logic                         pred_first,
  input  logic                         pred_second,
  input  logic [ADDR_W-1:0]            btb_target,
  input  logic [ADDR_W-1:0]            ras_top,
  input  logic                         q_full,
  output logic [ADDR_W-1:0]            fetch_addr,
  output logic                         grp_push,
  output logic [GROUP_MAX-1:0]         grp_mask,
  output logic [$clog2(GROUP_MAX+1)-1:0] grp_len,
  output logic [ADDR_W-1:0]            grp_next
);
  localparam int SLOT_W = $clog2(LINE_SLOTS);
  localparam int IDX_W  = SLOT_W + 1;
  localparam int LEN_W  = $clog2(GROUP_MAX + 1);

  logic [SLOT_W-1:0] start;
  logic [IDX_W-1:0]  idx;
  logic [SLOT_W-1:0] sl;
  logic              stop, seen_cond, to_ras, to_btb;

  assign start = fetch_addr[SLOT_W+1:2];

  always_comb begin
    grp_mask  = '0;
    grp_len   = '0;
    stop      = 1'b0;
    seen_cond = 1'b0;
    to_ras    = 1'b0;
    to_btb    = 1'b0;
    idx       = '0;
    sl        = '0;
    for (int k = 0; k < GROUP_MAX; k++) begin
      idx = IDX_W'(start) + IDX_W'(k);
      sl  = idx[SLOT_W-1:0];
      if (!stop && idx < IDX_W'(LINE_SLOTS)) begin
        grp_mask[k] = 1'b1;
        grp_len     = LEN_W'(k + 1);
        if (slot_ret[sl]) begin
          stop   = 1'b1;
          to_ras = 1'b1;
        end else if (slot_jump[sl]) begin
          stop   = 1'b1;
          to_btb = 1'b1;
        end else if (slot_cond[sl]) begin
          if (seen_cond ? pred_second : pred_first) begin
            stop   = 1'b1;
            to_btb = 1'b1;
          end else if (seen_cond) begin
            stop = 1'b1;
          end
          seen_cond = 1'b1;
        end
      end
    end
  end

  assign grp_next = to_ras ? ras_top :
                    to_btb ? btb_target :
                    fetch_addr + (ADDR_W'(grp_len) << 2);

  assign grp_push = rst_n && line_valid && !q_full;

  always_ff @(posedge clk) begin
    if (!rst_n)        fetch_addr <= RESET_ADDR[ADDR_W-1:0];
    else if (grp_push) fetch_addr <= grp_next;
  end
endmodule

// File: rtl/fetch_group_former_chk.sv
module fetch_group_former_chk #(
  parameter int GROUP_MAX  = 8,
  parameter int LINE_SLOTS = 16,
  parameter int ADDR_W     = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           line_valid,
  input logic                           q_full,
  input logic [ADDR_W-1:0]              fetch_addr,
  input logic                           grp_push,
  input logic [GROUP_MAX-1:0]           grp_mask,
  input logic [$clog2(GROUP_MAX+1)-1:0] grp_len,
  input logic [ADDR_W-1:0]              grp_next
);
  localparam int SLOT_W = $clog2(LINE_SLOTS);

  p_len_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(grp_len) <= GROUP_MAX);

  p_line_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(grp_len) + int'(fetch_addr[SLOT_W+1:2]) <= LINE_SLOTS);

  p_mask_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grp_mask) == int'(grp_len));

  p_stall_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full || !line_valid) |-> !grp_push);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full || !line_valid) |=> fetch_addr == $past(fetch_addr));

  p_advance_r12: assert property (@(posedge clk) disable iff (!rst_n)
    grp_push |=> fetch_addr == $past(grp_next));
endmodule

bind fetch_group_former fetch_group_former_chk #(
  .GROUP_MAX(GROUP_MAX), .LINE_SLOTS(LINE_SLOTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .q_full(q_full),
  .fetch_addr(fetch_addr), .grp_push(grp_push), .grp_mask(grp_mask),
  .grp_len(grp_len), .grp_next(grp_next)
);

// File: tb/fetch_group_former_tb.sv
module fetch_group_former_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_valid = 1'b0;
  logic [15:0] slot_cond = '0, slot_jump = '0, slot_ret = '0;
  logic        pred_first = 1'b0, pred_second = 1'b0;
  logic [31:0] btb_target = 32'h0000_8000;
  logic [31:0] ras_top = 32'h0000_9000;
  logic        q_full = 1'b0;
  logic [31:0] fetch_addr, grp_next;
  logic        grp_push;
  logic [7:0]  grp_mask;
  logic [3:0]  grp_len;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fetch_group_former u_dut (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .slot_cond(slot_cond),
    .slot_jump(slot_jump), .slot_ret(slot_ret), .pred_first(pred_first),
    .pred_second(pred_second), .btb_target(btb_target), .ras_top(ras_top),
    .q_full(q_full), .fetch_addr(fetch_addr), .grp_push(grp_push),
    .grp_mask(grp_mask), .grp_len(grp_len), .grp_next(grp_next));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic clear_line();
    slot_cond = '0; slot_jump = '0; slot_ret = '0;
    pred_first = 1'b0; pred_second = 1'b0; q_full = 1'b0; line_valid = 1'b1;
  endtask

  task automatic goto_addr(logic [31:0] a);
    @(negedge clk);
    clear_line();
    slot_ret = 16'hFFFF; ras_top = a;
    @(posedge clk); #1;
  endtask

  task automatic group_check(string req, logic [3:0] len, logic [31:0] nxt);
    #5;
    chk({req, " push"}, {31'd0, grp_push}, 32'd1);
    chk({req, " len"}, {28'd0, grp_len}, {28'd0, len});
    chk({req, " mask"}, {24'd0, grp_mask}, {24'd0, 8'((9'd1 << len) - 9'd1)});
    chk({req, " next"}, grp_next, nxt);
    @(posedge clk); #1;
    chk({req, " advance R12"}, fetch_addr, nxt);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset addr", fetch_addr, 32'h1000);
    @(negedge clk); rst_n = 1'b1; #2;
    chk("R1 no push", {31'd0, grp_push}, 32'd0);
  endtask

  task automatic t_straight();
    goto_addr(32'h1000);
    @(negedge clk); clear_line();
    group_check("R2 R10 straight", 4'd8, 32'h1020);
  endtask

  task automatic t_line_end();
    goto_addr(32'h1030);
    @(negedge clk); clear_line();
    group_check("R3 line end", 4'd4, 32'h1040);
  endtask

  task automatic t_first_nt();
    goto_addr(32'h1000);
    @(negedge clk); clear_line(); slot_cond[2] = 1'b1;
    group_check("R5 first not-taken", 4'd8, 32'h1020);
    goto_addr(32'h1000);
    @(negedge clk); clear_line(); slot_cond[2] = 1'b1; slot_cond[5] = 1'b1;
    group_check("R7 second not-taken", 4'd6, 32'h1018);
  endtask

  task automatic t_first_taken();
    goto_addr(32'h1000);
    @(negedge clk); clear_line(); slot_cond[3] = 1'b1; pred_first = 1'b1;
    btb_target = 32'h0000_8040;
    group_check("R6 first taken", 4'd4, 32'h8040);
  endtask

  task automatic t_second_taken();
    goto_addr(32'h1004);
    @(negedge clk); clear_line(); slot_cond[2] = 1'b1; slot_cond[5] = 1'b1;
    pred_second = 1'b1; btb_target = 32'h0000_8100;
    group_check("R7 second taken", 4'd5, 32'h8100);
  endtask

  task automatic t_return();
    goto_addr(32'h1000);
    @(negedge clk); clear_line(); slot_cond[0] = 1'b1; slot_ret[2] = 1'b1;
    btb_target = 32'h0000_8200; ras_top = 32'h0000_9300;
    group_check("R8 return", 4'd3, 32'h9300);
  endtask

  task automatic t_jump();
    goto_addr(32'h1020);
    @(negedge clk); clear_line(); slot_jump[8] = 1'b1;
    btb_target = 32'h0000_8400;
    group_check("R9 jump first slot", 4'd1, 32'h8400);
    goto_addr(32'h1000);
    @(negedge clk); clear_line(); slot_jump[6] = 1'b1;
    btb_target = 32'h0000_8500;
    group_check("R9 jump mid group", 4'd7, 32'h8500);
  endtask

  task automatic t_stall();
    goto_addr(32'h1010);
    @(negedge clk); clear_line(); q_full = 1'b1; #5;
    chk("R11 full no push", {31'd0, grp_push}, 32'd0);
    @(posedge clk); #1;
    chk("R11 full hold", fetch_addr, 32'h1010);
    @(negedge clk); clear_line(); line_valid = 1'b0; #5;
    chk("R11 no line no push", {31'd0, grp_push}, 32'd0);
    @(posedge clk); #1;
    chk("R11 no line hold", fetch_addr, 32'h1010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_straight();
    t_line_end();
    t_first_nt();
    t_first_taken();
    t_second_taken();
    t_return();
    t_jump();
    t_stall();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule